// File: doc/BRIEF.md
# CAN Error Interrupt Flag Unit

This unit sits beside a CAN protocol engine and turns its one-cycle event pulses into sticky flags that software can read and clear. Bus-level conditions such as bus-off entry, error passive or receive overrun land in an eight-bit error-factor register. The protocol error class of each bus error lands in a separate seven-bit error-code store. Each factor flag has its own enable bit. The enabled factor flags are reduced to one error-summary bit, which sits in a top-level status byte next to the receive-FIFO and transmit-FIFO event bits.

A single interrupt line is asserted whenever a status bit and its matching enable bit are both set. Software clears a flag by writing a byte with a 0 in that flag's position; a 1 in any position leaves the flag as it is. When a hardware set and a software clear hit the same flag in the same cycle, the set wins, so an event is never lost. The error-code store has two modes. In overwrite mode it shows only the latest error class. In accumulate mode, selected by its top bit, new classes are ORed into the bits already stored.

Register access uses a write strobe with a register select and a data byte. Reads go through a separate combinational select.

Top module: `can_err_irq_unit`

## Requirements
- R1: After reset, every register (select 0 to 4) reads 0x00 and `irq_o` is low.
- R2: A pulse on `fact_evt_i[k]` sets error-factor flag k (select 0), and the flag is visible from the next cycle. Bit map, 7 down to 0: bus lock, overload frame sent, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error.
- R3: A write to select 0 clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R4: If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R5: The factor-enable register (select 1) holds all eight written bits, with the same bit positions as the factor flags.
- R6: Top status bit 5 (select 3) is 1 exactly while some factor flag and its enable bit are both set. A flag whose enable bit is clear does not contribute.
- R7: The error-code store is at select 2. Its bits 6 down to 0 are: ACK delimiter, dominant bit, recessive bit, CRC, ACK, form, stuff. With bit 7 = 0 (overwrite mode), a nonzero `code_evt_i` replaces bits 6:0 with the event vector.
- R8: With bit 7 = 1 (accumulate mode), `code_evt_i` is ORed into the stored bits.
- R9: A write to select 2 loads bit 7 directly and clears each bit of 6:0 whose data bit is 0.
- R10: Top status bits 4 (receive FIFO) and 3 (transmit FIFO) are set by `rxf_evt_i` and `txf_evt_i` and cleared by writing 0 to those positions. A write cannot change bit 5, and bits 7:6 and 2:0 always read 0.
- R11: The top-enable register (select 4) keeps only bits 5, 4 and 3. `irq_o` is high exactly when the status byte ANDed with the top-enable byte is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fact_evt_i | input | 8 | Error-factor event pulses, one bit per factor |
| code_evt_i | input | 7 | Error-code event pulses |
| rxf_evt_i | input | 1 | Receive-FIFO event pulse |
| txf_evt_i | input | 1 | Transmit-FIFO event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 8 | Write data byte |
| rd_sel_i | input | 3 | Register select for the read |
| rd_data_o | output | 8 | Read data for rd_sel_i (combinational) |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench drives a hardware set and a software clear of the same factor flag in the same cycle. A design that lets the clear win would read 0x00 instead of 0x01. It switches the code store from overwrite to accumulate and back. A design that ignores the mode bit would either keep stale error classes or drop new ones. It masks a set factor flag with its enable bit, so a summary that skipped the enable would still report an error and hold the interrupt high. It also writes zeros over the whole status byte, so a summary bit that could be written would vanish even though its cause is still present.

// File: rtl/can_eiu_pkg.sv
package can_eiu_pkg;
    localparam int BYTE_W = 8;
    localparam int FACT_W = 8;
    localparam int CODE_W = 7;
    localparam int SEL_W  = 3;

    // top status bit positions
    localparam int TOP_ERR = 5;
    localparam int TOP_RXF = 4;
    localparam int TOP_TXF = 3;
    // code store mode bit
    localparam int CODE_ACC = 7;

    localparam logic [BYTE_W-1:0] TOP_MASK =
        BYTE_W'((1 << TOP_ERR) | (1 << TOP_RXF) | (1 << TOP_TXF));

    typedef enum logic [SEL_W-1:0] {
        SEL_FACT = 3'd0,
        SEL_FEN  = 3'd1,
        SEL_CODE = 3'd2,
        SEL_TOP  = 3'd3,
        SEL_TEN  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        reg_sel_e          sel;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    // true when this write targets register s
    function automatic logic wr_hit(wr_req_t w, reg_sel_e s);
        return w.en && (w.sel == s);
    endfunction
endpackage

// File: rtl/eiu_w0c_flags.sv
module eiu_w0c_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] keep_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flags_q;

    for (genvar k = 0; k < W; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                flags_q[k] <= 1'b0;
            else
                flags_q[k] <= (flags_q[k] & keep_i[k]) | set_i[k];
        end
    end

    assign flags_o = flags_q;

    // R4: a set pulse always leaves its flag set, even under a clear
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));

    // R3: with no clear and no set the flags hold
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((&keep_i) && (set_i == '0)) |=> $stable(flags_q));
endmodule

// File: rtl/eiu_cfg_reg.sv
module eiu_cfg_reg #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load_i)
            q <= data_i & MASK;
    end

    assign q_o = q;
endmodule

// File: rtl/eiu_code_store.sv
module eiu_code_store
    import can_eiu_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] evt_i,
    input  logic          wr_hit_i,
    input  logic [CW:0]   wr_data_i,
    output logic [CW:0]   store_o
);
    logic          mode_q;
    logic [CW-1:0] codes_q;
    logic [CW-1:0] keep;

    assign keep = wr_hit_i ? wr_data_i[CW-1:0] : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            codes_q <= '0;
        end else begin
            if (wr_hit_i)
                mode_q <= wr_data_i[CW];
            if (!mode_q && (|evt_i))
                codes_q <= evt_i;
            else
                codes_q <= (codes_q & keep) | evt_i;
        end
    end

    assign store_o = {mode_q, codes_q};

    // R7: overwrite mode replaces the field with the new event vector
    ovr_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && (|evt_i)) |=> (codes_q == $past(evt_i)));

    // R8: accumulate mode with no write loses no stored bit
    acc_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q && !wr_hit_i) |=> ((codes_q & $past(codes_q)) == $past(codes_q)));
endmodule

// File: rtl/eiu_irq_combine.sv
module eiu_irq_combine
    import can_eiu_pkg::*;
(
    input  logic [FACT_W-1:0] fact_flags_i,
    input  logic [FACT_W-1:0] fact_en_i,
    input  logic              rxf_i,
    input  logic              txf_i,
    input  logic [BYTE_W-1:0] top_en_i,
    output logic [BYTE_W-1:0] status_o,
    output logic              irq_o
);
    always_comb begin
        status_o          = '0;
        status_o[TOP_ERR] = |(fact_flags_i & fact_en_i);
        status_o[TOP_RXF] = rxf_i;
        status_o[TOP_TXF] = txf_i;
    end

    assign irq_o = |(status_o & top_en_i);
endmodule

// File: rtl/can_err_irq_unit.sv
module can_err_irq_unit
    import can_eiu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FACT_W-1:0] fact_evt_i,
    input  logic [CODE_W-1:0] code_evt_i,
    input  logic              rxf_evt_i,
    input  logic              txf_evt_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              irq_o
);
    wr_req_t           wr_req;
    logic [FACT_W-1:0] fact_keep;
    logic [FACT_W-1:0] fact_flags;
    logic [FACT_W-1:0] fact_en;
    logic [1:0]        top_keep;
    logic [1:0]        top_flags;
    logic [BYTE_W-1:0] top_en;
    logic [BYTE_W-1:0] code_store;
    logic [BYTE_W-1:0] status;

    assign wr_req    = '{en: wr_en_i, sel: reg_sel_e'(wr_sel_i), data: wr_data_i};
    assign fact_keep = wr_hit(wr_req, SEL_FACT) ? wr_req.data : '1;
    assign top_keep  = wr_hit(wr_req, SEL_TOP)
                       ? {wr_req.data[TOP_RXF], wr_req.data[TOP_TXF]} : 2'b11;

    eiu_w0c_flags #(.W(FACT_W)) u_fact_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (fact_evt_i),
        .keep_i  (fact_keep),
        .flags_o (fact_flags)
    );

    eiu_cfg_reg #(.W(FACT_W), .MASK('1)) u_fact_en (
        .clk    (clk),
        .rst    (rst),
        .load_i (wr_hit(wr_req, SEL_FEN)),
        .data_i (wr_req.data),
        .q_o    (fact_en)
    );

    eiu_code_store #(.CW(CODE_W)) u_code_store (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (code_evt_i),
        .wr_hit_i  (wr_hit(wr_req, SEL_CODE)),
        .wr_data_i (wr_req.data),
        .store_o   (code_store)
    );

    eiu_w0c_flags #(.W(2)) u_top_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   ({rxf_evt_i, txf_evt_i}),
        .keep_i  (top_keep),
        .flags_o (top_flags)
    );

    eiu_cfg_reg #(.W(BYTE_W), .MASK(TOP_MASK)) u_top_en (
        .clk    (clk),
        .rst    (rst),
        .load_i (wr_hit(wr_req, SEL_TEN)),
        .data_i (wr_req.data),
        .q_o    (top_en)
    );

    eiu_irq_combine u_combine (
        .fact_flags_i (fact_flags),
        .fact_en_i    (fact_en),
        .rxf_i        (top_flags[1]),
        .txf_i        (top_flags[0]),
        .top_en_i     (top_en),
        .status_o     (status),
        .irq_o        (irq_o)
    );

    always_comb begin
        case (reg_sel_e'(rd_sel_i))
            SEL_FACT: rd_data_o = fact_flags;
            SEL_FEN:  rd_data_o = fact_en;
            SEL_CODE: rd_data_o = code_store;
            SEL_TOP:  rd_data_o = status;
            SEL_TEN:  rd_data_o = top_en;
            default:  rd_data_o = '0;
        endcase
    end

    // R11: writing zero to the top enables silences the line next cycle
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && (wr_sel_i == 3'd4) && (wr_data_i == '0)) |=> !irq_o);

    // R2: a factor event is readable as a set flag next cycle
    fact_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|fact_evt_i) |=> ((fact_flags & $past(fact_evt_i)) != '0));
endmodule

// File: tb/can_err_irq_unit_bench.sv
`timescale 1ns/1ps
module can_err_irq_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] fact_evt = '0;
    logic [6:0] code_evt = '0;
    logic       rxf_evt = 1'b0;
    logic       txf_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] sel;
        logic [7:0] val;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    can_err_irq_unit u_can_err_irq_unit (
        .clk        (clk),
        .rst        (rst),
        .fact_evt_i (fact_evt),
        .code_evt_i (code_evt),
        .rxf_evt_i  (rxf_evt),
        .txf_evt_i  (txf_evt),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .rd_sel_i   (rd_sel),
        .rd_data_o  (rd_data),
        .irq_o      (irq)
    );

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                rd_sel = e.sel;
                #1;
                checks++;
                if (rd_data !== e.val || irq !== e.irq) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual data=%02h irq=%0b expected data=%02h irq=%0b",
                             e.tag, e.sel, rd_data, irq, e.val, e.irq);
                end
            end
        end
    end

    task automatic expect_reg(input logic [2:0] sel, input logic [7:0] val,
                              input logic exp_irq, input string tag);
        sb.push_back('{sel: sel, val: val, irq: exp_irq, tag: tag});
        @(negedge clk);
        #2;
    endtask

    task automatic write_reg(input logic [2:0] sel, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] f, input logic [6:0] c,
                         input logic rx, input logic tx);
        @(posedge clk); #1;
        fact_evt = f; code_evt = c; rxf_evt = rx; txf_evt = tx;
        @(posedge clk); #1;
        fact_evt = '0; code_evt = '0; rxf_evt = 1'b0; txf_evt = 1'b0;
    endtask

    task automatic set_and_clear(input logic [7:0] f, input logic [7:0] d);
        @(posedge clk); #1;
        fact_evt = f; wr_en = 1'b1; wr_sel = 3'd0; wr_data = d;
        @(posedge clk); #1;
        fact_evt = '0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        for (int s = 0; s < 5; s++) expect_reg(3'(s), 8'h00, 1'b0, "R1 reset");

        // R2 error passive (bit 2)
        pulse(8'h04, '0, 1'b0, 1'b0);
        expect_reg(3'd0, 8'h04, 1'b0, "R2 factor set");
        // R5 enable register
        write_reg(3'd1, 8'h04);
        expect_reg(3'd1, 8'h04, 1'b0, "R5 factor enable");
        // R6 summary on
        expect_reg(3'd3, 8'h20, 1'b0, "R6 summary set");
        // R11 top enable masks unused bits, irq asserts
        write_reg(3'd4, 8'hFF);
        expect_reg(3'd4, 8'h38, 1'b1, "R11 top enable");

        // R2 bus lock (bit 7), not enabled
        pulse(8'h80, '0, 1'b0, 1'b0);
        expect_reg(3'd0, 8'h84, 1'b1, "R2 second factor");
        // R3 write zero at bit 2 only
        write_reg(3'd0, 8'hFB);
        expect_reg(3'd0, 8'h80, 1'b0, "R3 write-zero clear");
        // R6 disabled flag does not count
        expect_reg(3'd3, 8'h00, 1'b0, "R6 disabled flag");

        // R3 clear all, then R4 set vs clear collision on bus error (bit 0)
        write_reg(3'd0, 8'h00);
        expect_reg(3'd0, 8'h00, 1'b0, "R3 clear all");
        set_and_clear(8'h01, 8'h00);
        expect_reg(3'd0, 8'h01, 1'b0, "R4 set wins");

        // R7 overwrite mode: CRC (bit 3) then stuff (bit 0)
        pulse('0, 7'h08, 1'b0, 1'b0);
        expect_reg(3'd2, 8'h08, 1'b0, "R7 first code");
        pulse('0, 7'h01, 1'b0, 1'b0);
        expect_reg(3'd2, 8'h01, 1'b0, "R7 overwrite");

        // R9 set accumulate mode, keep bit 0
        write_reg(3'd2, 8'h81);
        expect_reg(3'd2, 8'h81, 1'b0, "R9 mode write");
        // R8 accumulate dominant bit error (bit 5)
        pulse('0, 7'h20, 1'b0, 1'b0);
        expect_reg(3'd2, 8'hA1, 1'b0, "R8 accumulate");
        // R9 clear bit 0 only
        write_reg(3'd2, 8'hA0);
        expect_reg(3'd2, 8'hA0, 1'b0, "R9 code clear");
        // R9 mode back off, bit 5 kept
        write_reg(3'd2, 8'h20);
        expect_reg(3'd2, 8'h20, 1'b0, "R9 mode off");
        // R7 overwrite again: form error (bit 1)
        pulse('0, 7'h02, 1'b0, 1'b0);
        expect_reg(3'd2, 8'h02, 1'b0, "R7 overwrite after mode off");

        // R10 FIFO status bits
        pulse('0, '0, 1'b1, 1'b0);
        expect_reg(3'd3, 8'h10, 1'b1, "R10 rx fifo set");
        pulse('0, '0, 1'b0, 1'b1);
        expect_reg(3'd3, 8'h18, 1'b1, "R10 tx fifo set");
        write_reg(3'd3, 8'hEF);
        expect_reg(3'd3, 8'h08, 1'b1, "R10 rx clear only");
        // enable bus error -> summary, then try to write it away
        write_reg(3'd1, 8'h01);
        expect_reg(3'd3, 8'h28, 1'b1, "R6 summary via enable");
        write_reg(3'd3, 8'h00);
        expect_reg(3'd3, 8'h20, 1'b1, "R10 summary not writable");
        // R11 disable all top sources
        write_reg(3'd4, 8'h00);
        expect_reg(3'd4, 8'h00, 1'b0, "R11 irq masked");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule